// File: doc/BRIEF.md
# Timer-Triggered ADC Conversion Sequencer

This block sits between a set of timer compare units and an analog-to-digital converter. Any of four compare-match pulses can start one conversion of the one analog input picked by a 2-bit channel field. The block sends a one-cycle start strobe to the converter and raises a status bit while the conversion runs. It waits for the converter's done strobe, writes the returned word into the result register that belongs to the picked channel, and then emits a one-cycle completion pulse.

Two operating styles are supported. In one-shot style the sequencer accepts exactly four conversions and then ignores triggers until a restart event re-arms it. The restart event stands for a timer clear edge or a timer-enable write. In loop style it keeps accepting triggers for as long as the enable bit is held high. The triggers can come in any order, and the same trigger can repeat.

Top module: `adc_trig_seq`

## Requirements
- R1: With enable high, no conversion running and the block not halted, a trigger pulse on any trigger bit sampled at a clock edge makes `cvt_start` high for exactly the following cycle and sets `conv_busy` in that same cycle.
- R2: Several trigger bits high in the same cycle count as one accepted trigger. They produce one start strobe and use up one of the four one-shot conversions.
- R3: A trigger that arrives while `conv_busy` is high is dropped. It produces no start and does not count toward the one-shot limit. This includes a trigger in the same cycle as the done strobe.
- R4: When `cvt_done` is high at a clock edge while a conversion runs, `cvt_data` is stored into `res_o[ch]`, where `ch` is the `chan_sel` value sampled with the accepted trigger. The other result registers keep their values, and each register holds its value until its next write.
- R5: The edge that captures the result also clears `conv_busy`. `conv_irq` is high for exactly the one cycle after that edge.
- R6: In one-shot mode (`loop_mode`=0), once four triggers have been accepted since the last re-arm, every further trigger is ignored.
- R7: A `restart` pulse re-arms one-shot counting from zero. A trigger in the same cycle as `restart` is accepted and counts as the first of the new four.
- R8: In loop mode (`loop_mode`=1), every trigger that arrives while idle starts a conversion, with no limit on the count.
- R9: With `enable` low, no trigger is accepted, `conv_busy` is cleared at the next edge, a done strobe is neither captured nor signalled, and the one-shot count returns to zero.
- R10: After reset, `cvt_start`, `conv_busy`, `conv_irq` and all result registers are zero.
- R11: A done strobe that arrives while no conversion is running is ignored. It causes no interrupt and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; low aborts and re-arms |
| loop_mode | input | 1 | 0 = one-shot (four conversions), 1 = loop |
| chan_sel | input | 2 | Analog input / result register index |
| trig | input | 4 | Compare-match trigger pulses |
| restart | input | 1 | Re-arm pulse for one-shot counting |
| cvt_done | input | 1 | Converter done strobe |
| cvt_data | input | 12 | Converter result word |
| cvt_start | output | 1 | One-cycle start strobe to the converter |
| conv_busy | output | 1 | Conversion-status bit |
| conv_irq | output | 1 | One-cycle completion pulse |
| res_o | output | 4x12 | Result registers, indexed by channel |

## Verification
Two events can fall in the same cycle: a conversion finishing and a new trigger arriving. The bench raises the done strobe and all four trigger bits together at one edge. It then checks that the interrupt fires and the result is stored, and that no start strobe follows. A restart and a trigger can also coincide. The bench drives both in one cycle while the block is halted and expects a start. It then counts the remaining accepts, which shows the coincident trigger was counted as the first of the new four.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SEQ_ONESHOT = 1'b0,
    SEQ_LOOP    = 1'b1
  } seq_mode_e;

  localparam int unsigned SEQ_SHOTS_DEFAULT = 4;

endpackage

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int unsigned NTRIG = 4
) (
  input  logic [NTRIG-1:0] trig,
  input  logic             enable,
  input  logic             busy,
  input  logic             halted,
  input  logic             restart,
  output logic             trig_any,
  output logic             accept
);

  function automatic logic any_hit(input logic [NTRIG-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NTRIG; i++) r = r | v[i];
    return r;
  endfunction

  always_comb begin
    trig_any = any_hit(trig);
    accept   = enable && trig_any && !busy && (!halted || restart);
  end

endmodule

// File: rtl/adc_shot_ctr.sv
module adc_shot_ctr #(
  parameter int unsigned SHOTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic loop_mode,
  input  logic restart,
  input  logic accept,
  output logic halted
);

  localparam int unsigned CNT_W = $clog2(SHOTS + 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic en, input logic lp, input logic rs, input logic acc
  );
    if (!en)      return '0;
    else if (rs)  return acc ? CNT_W'(1) : '0;
    else if (acc && !lp) return cur + CNT_W'(1);
    else          return cur;
  endfunction

  always_comb begin
    count_d = next_count(count_q, enable, loop_mode, restart, accept);
    halted  = !loop_mode && (count_q == CNT_W'(SHOTS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(SHOTS)); // R6
  AST_RESTART_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && enable) |=> !halted); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count_q == '0)); // R9

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [$clog2(NCH)-1:0]    wr_sel,
  input  logic [DW-1:0]             wr_data,
  output logic [NCH-1:0][DW-1:0]    res_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    logic hit;
    assign hit = wr && (wr_sel == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_o[g] <= '0;
      else if (hit) res_o[g] <= wr_data;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(res_o)); // R4

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int unsigned NTRIG = 4,
  parameter int unsigned NCH   = 4,
  parameter int unsigned DW    = 12,
  parameter int unsigned SHOTS = adc_seq_pkg::SEQ_SHOTS_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   loop_mode,
  input  logic [$clog2(NCH)-1:0] chan_sel,
  input  logic [NTRIG-1:0]       trig,
  input  logic                   restart,
  input  logic                   cvt_done,
  input  logic [DW-1:0]          cvt_data,
  output logic                   cvt_start,
  output logic                   conv_busy,
  output logic                   conv_irq,
  output logic [NCH-1:0][DW-1:0] res_o
);

  localparam int unsigned CHW = $clog2(NCH);

  logic           trig_any;
  logic           accept;
  logic           halted;
  logic           capture;
  logic           busy_q;
  logic           start_q;
  logic           irq_q;
  logic [CHW-1:0] sel_q;

  adc_trig_gate #(.NTRIG(NTRIG)) i_gate (
    .trig     (trig),
    .enable   (enable),
    .busy     (busy_q),
    .halted   (halted),
    .restart  (restart),
    .trig_any (trig_any),
    .accept   (accept)
  );

  adc_shot_ctr #(.SHOTS(SHOTS)) i_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .loop_mode (loop_mode),
    .restart   (restart),
    .accept    (accept),
    .halted    (halted)
  );

  assign capture = enable && busy_q && cvt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      start_q <= accept;
      irq_q   <= capture;
      if (accept) sel_q <= chan_sel;
      if (!enable)      busy_q <= 1'b0;
      else if (accept)  busy_q <= 1'b1;
      else if (capture) busy_q <= 1'b0;
    end
  end

  adc_result_bank #(.NCH(NCH), .DW(DW)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (capture),
    .wr_sel  (sel_q),
    .wr_data (cvt_data),
    .res_o   (res_o)
  );

  assign cvt_start = start_q;
  assign conv_busy = busy_q;
  assign conv_irq  = irq_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_start |=> !cvt_start); // R1
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_start |-> conv_busy); // R1
  AST_BUSY_DROPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !cvt_start); // R3
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_irq |=> !conv_irq); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_irq |-> !conv_busy); // R5
  AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> !cvt_start); // R6
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!conv_busy && !cvt_start && !conv_irq)); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_busy && cvt_done) |=> !conv_irq); // R11

endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic loop_mode = 1'b0;
  logic [1:0] chan_sel = 2'd0;
  logic [3:0] trig = 4'd0;
  logic restart = 1'b0;
  logic cvt_done = 1'b0;
  logic [DW-1:0] cvt_data = '0;
  logic cvt_start, conv_busy, conv_irq;
  logic [3:0][DW-1:0] res_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [DW-1:0] res_m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .loop_mode(loop_mode),
    .chan_sel(chan_sel), .trig(trig), .restart(restart),
    .cvt_done(cvt_done), .cvt_data(cvt_data), .cvt_start(cvt_start),
    .conv_busy(conv_busy), .conv_irq(conv_irq), .res_o(res_o)
  );

  // {trig[19:16], chan[15:14], loop[13], data[12:1], expect_start[0]}
  localparam logic [19:0] VEC [12] = '{
    {4'b0100, 2'd2, 1'b0, 12'h123, 1'b1},
    {4'b0010, 2'd2, 1'b0, 12'h456, 1'b1},
    {4'b1000, 2'd2, 1'b0, 12'h789, 1'b1},
    {4'b0001, 2'd2, 1'b0, 12'hABC, 1'b1},
    {4'b0001, 2'd2, 1'b0, 12'h111, 1'b0},
    {4'b1111, 2'd2, 1'b0, 12'h222, 1'b0},
    {4'b1111, 2'd1, 1'b1, 12'h001, 1'b1},
    {4'b0010, 2'd1, 1'b1, 12'h002, 1'b1},
    {4'b0010, 2'd3, 1'b1, 12'h3FF, 1'b1},
    {4'b0010, 2'd0, 1'b1, 12'hFFF, 1'b1},
    {4'b0100, 2'd0, 1'b1, 12'h0F0, 1'b1},
    {4'b1000, 2'd2, 1'b1, 12'h5A5, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(res_o[c]), 32'(res_m[c]));
  endtask

  // trigger pulse for one cycle; returns at sample point after the accept edge
  task automatic pulse(input logic [3:0] p);
    trig = p;
    tick();
    trig = 4'd0;
  endtask

  task automatic finish_conv(input logic [1:0] ch, input logic [DW-1:0] d, input string req);
    cvt_done = 1'b1;
    cvt_data = d;
    tick();
    cvt_done = 1'b0;
    res_m[ch] = d;
    chk(req, 32'(conv_irq), 32'd1);
    chk(req, 32'(conv_busy), 32'd0);
    chk_res(req);
    tick();
    chk(req, 32'(conv_irq), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) res_m[c] = '0;
    repeat (3) tick();
    // R10: reset state
    chk("R10", 32'(cvt_start), 32'd0);
    chk("R10", 32'(conv_busy), 32'd0);
    chk("R10", 32'(conv_irq), 32'd0);
    chk_res("R10");
    rst_n = 1'b1;
    enable = 1'b1;
    tick();

    // Table: R1 R2 R4 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      logic [19:0] v;
      v = VEC[i];
      chan_sel = v[15:14];
      loop_mode = v[13];
      pulse(v[19:16]);
      chk("R1/R6/R8 start", 32'(cvt_start), 32'(v[0]));
      chk("R1/R6/R8 busy", 32'(conv_busy), 32'(v[0]));
      if (v[0]) begin
        cvt_done = 1'b1;
        cvt_data = v[12:1];
        tick();
        cvt_done = 1'b0;
        chk("R2 single start", 32'(cvt_start), 32'd0);
        res_m[v[15:14]] = v[12:1];
        chk("R5 irq", 32'(conv_irq), 32'd1);
        chk("R5 busy clear", 32'(conv_busy), 32'd0);
        chk_res("R4 result");
        tick();
        chk("R5 irq width", 32'(conv_irq), 32'd0);
      end else begin
        tick();
        chk_res("R6 unchanged");
      end
    end

    // R6: back to one-shot with count still at limit
    loop_mode = 1'b0;
    pulse(4'b0001);
    chk("R6 halted", 32'(cvt_start), 32'd0);
    tick();

    // R7: restart with trigger in the same cycle
    chan_sel = 2'd3;
    restart = 1'b1;
    pulse(4'b0100);
    restart = 1'b0;
    chk("R7 restart accept", 32'(cvt_start), 32'd1);
    finish_conv(2'd3, 12'h0AA, "R7");

    // R3: trigger while busy is dropped and not counted
    pulse(4'b0001);
    chk("R3 accept2", 32'(cvt_start), 32'd1);
    pulse(4'b1000);
    chk("R3 dropped", 32'(cvt_start), 32'd0);
    finish_conv(2'd3, 12'h0BB, "R3");
    pulse(4'b0010);
    chk("R3 accept3", 32'(cvt_start), 32'd1);
    finish_conv(2'd3, 12'h0CC, "R3");
    pulse(4'b0010);
    chk("R3 accept4", 32'(cvt_start), 32'd1);
    finish_conv(2'd3, 12'h0DD, "R3");
    pulse(4'b0100);
    chk("R6 fifth ignored", 32'(cvt_start), 32'd0);
    tick();

    // R9: disable re-arms, aborts, suppresses capture
    enable = 1'b0;
    tick();
    enable = 1'b1;
    chan_sel = 2'd1;
    pulse(4'b0001);
    chk("R9 rearm", 32'(cvt_start), 32'd1);
    enable = 1'b0;
    tick();
    chk("R9 busy clear", 32'(conv_busy), 32'd0);
    cvt_done = 1'b1;
    cvt_data = 12'h777;
    tick();
    cvt_done = 1'b0;
    chk("R9 no irq", 32'(conv_irq), 32'd0);
    chk_res("R9 no capture");
    pulse(4'b1111);
    chk("R9 no start", 32'(cvt_start), 32'd0);
    enable = 1'b1;
    tick();

    // R11: done while idle
    cvt_done = 1'b1;
    cvt_data = 12'h999;
    tick();
    cvt_done = 1'b0;
    chk("R11 no irq", 32'(conv_irq), 32'd0);
    tick();
    chk("R11 no irq", 32'(conv_irq), 32'd0);
    chk_res("R11 unchanged");

    // R2: all-bits triggers each count once in one-shot
    restart = 1'b1;
    tick();
    restart = 1'b0;
    chan_sel = 2'd0;
    for (int k = 0; k < 4; k++) begin
      pulse(4'b1111);
      chk("R2 multi accept", 32'(cvt_start), 32'd1);
      finish_conv(2'd0, DW'(12'h100 + k), "R2");
    end
    pulse(4'b1111);
    chk("R2/R6 limit", 32'(cvt_start), 32'd0);
    tick();

    // R3/R5: done and trigger in the same cycle
    loop_mode = 1'b1;
    chan_sel = 2'd2;
    pulse(4'b0001);
    chk("R8 loop start", 32'(cvt_start), 32'd1);
    cvt_done = 1'b1;
    cvt_data = 12'h4E4;
    trig = 4'b1111;
    tick();
    cvt_done = 1'b0;
    trig = 4'd0;
    res_m[2] = 12'h4E4;
    chk("R5 coincident irq", 32'(conv_irq), 32'd1);
    chk("R3 coincident drop", 32'(cvt_start), 32'd0);
    chk_res("R4 coincident");
    tick();
    chk("R3 coincident busy", 32'(conv_busy), 32'd0);
    chk("R3 coincident start", 32'(cvt_start), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule